// File: doc/BRIEF.md
# Non-Stalling Microcontroller-to-Peripheral Access Bridge

The bridge connects an 8-bit microcontroller bus to a peripheral that can stretch each access for a variable time. The microcontroller bus multiplexes address and data on one byte-wide lane, marks the address phase with an address-latch-enable pulse, and has separate read and write strobes. The microcontroller has no wait or ready input, so it cannot be held. The bridge takes each peripheral access, freezes it and carries it out on its own. The peripheral may need a long time to respond because its internal conversion runs on a slow frame base. Software learns that the access has finished by polling a busy flag. All microcontroller bus inputs are sampled on the bridge clock. The peripheral strobes are registered state outputs. The peripheral's data-acknowledge is asynchronous and passes through a two-flop synchroniser.

A write is done in one step. The byte is held in a buffer and drives the peripheral until the acknowledge arrives. A read is done in two steps. The first read of a peripheral address starts the access and returns whatever the read-holding buffer contained before. Once busy clears, software reads the read-holding address to get the new byte.

Address map (default parameters): addresses whose two top bits are 00 form the peripheral window, and the low six bits become the peripheral address. 0xFE is the status register: bit 0 is busy, bit 1 is the sticky overrun flag, and bits 7..2 read as zero. 0xFF is the read-holding buffer. All other addresses are unmapped. The transfer controller has three states. ST_IDLE goes to ST_WR_WAIT on a write start to the window. ST_IDLE goes to ST_RD_WAIT on a read start to the window, and a write takes precedence if both start together. ST_RD_WAIT and ST_WR_WAIT both return to ST_IDLE on a rising edge of the synchronised acknowledge.

Top module: `cpu_periph_bridge`

## Requirements
- R1: After reset the controller is in ST_IDLE, per_rd and per_wr are 0, and a read of 0xFE returns 0x00.
- R2: The address byte is the value on cpu_ad_in at the first clock edge after cpu_ale falls. Changes on cpu_ad_in at any other time do not move the latched address.
- R3: A write start to the peripheral window raises per_wr within one clock, with per_addr equal to address bits 5..0 and per_wdata equal to the written byte. Both values stay stable until the access ends, and per_rd and per_wr are never high together.
- R4: A read start to the peripheral window raises per_rd with per_addr equal to address bits 5..0. During that CPU read, cpu_ad_out returns the previous content of the read-holding buffer.
- R5: The strobe that was raised stays high for exactly two clock edges after per_ack is first sampled high and drops at the third edge.
- R6: At the edge where a read ends, per_rdata is captured. A later CPU read of 0xFF returns that byte.
- R7: A read of 0xFE returns busy in bit 0, which is 1 from the start of a peripheral access until it ends, and overrun in bit 1. Bits 7..2 are 0.
- R8: A read or write start to the window while busy is ignored: the strobe type, per_addr and per_wdata are unchanged. It sets the sticky overrun bit.
- R9: A CPU write to 0xFE with bit 1 set clears overrun. A write with bit 1 clear leaves it set.
- R10: An acknowledge that stays high after an access ends does not end the next access. Ending it needs a new low-to-high transition of per_ack.
- R11: Reads and writes to unmapped addresses raise no peripheral strobe, do not drive cpu_ad_oe, and leave the status and the read-holding byte unchanged.
- R12: cpu_ad_oe is 1 only while cpu_rd is high and the latched address is in the window, 0xFE or 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_ad_in | input | 8 | Multiplexed address/data lane from the microcontroller |
| cpu_ad_out | output | 8 | Read data toward the microcontroller |
| cpu_ad_oe | output | 1 | Drive enable for cpu_ad_out |
| cpu_ale | input | 1 | Address latch enable, active high |
| cpu_rd | input | 1 | Read strobe, active high |
| cpu_wr | input | 1 | Write strobe, active high |
| per_rd | output | 1 | Frozen peripheral read strobe |
| per_wr | output | 1 | Frozen peripheral write strobe |
| per_addr | output | 6 | Frozen peripheral address |
| per_wdata | output | 8 | Buffered write byte |
| per_rdata | input | 8 | Peripheral read data |
| per_ack | input | 1 | Asynchronous peripheral data-acknowledge |

## Verification
The bench walks every window address for both writes and reads, with arithmetically generated data, and walks every unmapped address. A decoder with a wrong window boundary would strobe the peripheral on a foreign address or miss a legal one. It times the acknowledge path edge by edge, which exposes a synchroniser with a missing or extra stage. It starts second accesses while busy, so a design that let them through would corrupt per_addr or per_wdata. It also holds the acknowledge high across accesses, so a level-sensitive completion would end the next access at once. Stale-data return on the first read step and the set-wins, write-one-to-clear rules of overrun are checked through the status byte.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_WAIT = 2'd1,
        ST_WR_WAIT = 2'd2
    } xfer_state_e;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_PERIPH = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_RDHOLD = 2'd3
    } region_e;

    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_OVR_BIT  = 1;

endpackage

// File: rtl/bridge_addr_decode.sv
module bridge_addr_decode
    import bridge_pkg::*;
#(
    parameter int          DW        = 8,
    parameter int          PA_W      = 6,
    parameter int unsigned PER_TAG   = 0,
    parameter int unsigned STAT_ADDR = 8'hFE,
    parameter int unsigned RDAT_ADDR = 8'hFF
) (
    input  logic [DW-1:0] addr,
    output region_e       region
);
    localparam int TAG_W = DW - PA_W;

    always_comb begin
        if (addr[DW-1:PA_W] == TAG_W'(PER_TAG))
            region = SEL_PERIPH;
        else if (addr == DW'(STAT_ADDR))
            region = SEL_STATUS;
        else if (addr == DW'(RDAT_ADDR))
            region = SEL_RDHOLD;
        else
            region = SEL_NONE;
    end
endmodule

// File: rtl/bridge_sync.sv
module bridge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++)
                chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bridge_xfer_fsm.sv
module bridge_xfer_fsm
    import bridge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_rd,
    input  logic start_wr,
    input  logic ack_rise,
    input  logic clr_ovr,
    output logic busy,
    output logic overrun,
    output logic accept,
    output logic rd_done,
    output logic per_rd,
    output logic per_wr
);
    xfer_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_wr)      state_nx = ST_WR_WAIT;
                else if (start_rd) state_nx = ST_RD_WAIT;
            end
            ST_RD_WAIT: if (ack_rise) state_nx = ST_IDLE;
            ST_WR_WAIT: if (ack_rise) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        busy    = (state != ST_IDLE);
        per_rd  = (state == ST_RD_WAIT);
        per_wr  = (state == ST_WR_WAIT);
        accept  = (state == ST_IDLE) && (start_rd || start_wr);
        rd_done = (state == ST_RD_WAIT) && ack_rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            overrun <= 1'b0;
        else if ((state != ST_IDLE) && (start_rd || start_wr))
            overrun <= 1'b1;
        else if (clr_ovr)
            overrun <= 1'b0;
    end
endmodule

// File: rtl/cpu_periph_bridge.sv
module cpu_periph_bridge
    import bridge_pkg::*;
#(
    parameter int          DW          = 8,
    parameter int          PA_W        = 6,
    parameter int unsigned PER_TAG     = 0,
    parameter int unsigned STAT_ADDR   = 8'hFE,
    parameter int unsigned RDAT_ADDR   = 8'hFF,
    parameter int          SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   cpu_ad_in,
    output logic [DW-1:0]   cpu_ad_out,
    output logic            cpu_ad_oe,
    input  logic            cpu_ale,
    input  logic            cpu_rd,
    input  logic            cpu_wr,
    output logic            per_rd,
    output logic            per_wr,
    output logic [PA_W-1:0] per_addr,
    output logic [DW-1:0]   per_wdata,
    input  logic [DW-1:0]   per_rdata,
    input  logic            per_ack
);
    logic          ale_q, rd_q, wr_q, ack_q, ack_s;
    logic [DW-1:0] addr_q, rdata_q, status;
    region_e       region;
    logic          rd_start, wr_start, per_hit, ack_rise, clr_ovr;
    logic          busy, overrun, accept, rd_done;

    // bus sampling and address capture on the falling edge of ALE
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ale_q  <= 1'b0;
            rd_q   <= 1'b0;
            wr_q   <= 1'b0;
            ack_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            ale_q <= cpu_ale;
            rd_q  <= cpu_rd;
            wr_q  <= cpu_wr;
            ack_q <= ack_s;
            if (ale_q && !cpu_ale)
                addr_q <= cpu_ad_in;
        end
    end

    bridge_addr_decode #(
        .DW(DW), .PA_W(PA_W), .PER_TAG(PER_TAG),
        .STAT_ADDR(STAT_ADDR), .RDAT_ADDR(RDAT_ADDR)
    ) u_dec (
        .addr   (addr_q),
        .region (region)
    );

    bridge_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (per_ack),
        .q     (ack_s)
    );

    assign rd_start = cpu_rd && !rd_q;
    assign wr_start = cpu_wr && !wr_q;
    assign per_hit  = (region == SEL_PERIPH);
    assign ack_rise = ack_s && !ack_q;
    assign clr_ovr  = wr_start && (region == SEL_STATUS) && cpu_ad_in[STAT_OVR_BIT];

    bridge_xfer_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_rd (rd_start && per_hit),
        .start_wr (wr_start && per_hit),
        .ack_rise (ack_rise),
        .clr_ovr  (clr_ovr),
        .busy     (busy),
        .overrun  (overrun),
        .accept   (accept),
        .rd_done  (rd_done),
        .per_rd   (per_rd),
        .per_wr   (per_wr)
    );

    // frozen address, write buffer and read-holding buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_addr  <= '0;
            per_wdata <= '0;
            rdata_q   <= '0;
        end else begin
            if (accept) begin
                per_addr <= addr_q[PA_W-1:0];
                if (wr_start)
                    per_wdata <= cpu_ad_in;
            end
            if (rd_done)
                rdata_q <= per_rdata;
        end
    end

    always_comb begin
        status                = '0;
        status[STAT_BUSY_BIT] = busy;
        status[STAT_OVR_BIT]  = overrun;
        cpu_ad_oe  = cpu_rd && (region != SEL_NONE);
        cpu_ad_out = (region == SEL_STATUS) ? status : rdata_q;
    end
endmodule

// File: rtl/bridge_chk.sv
module bridge_chk #(
    parameter int DW   = 8,
    parameter int PA_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            per_rd,
    input logic            per_wr,
    input logic [PA_W-1:0] per_addr,
    input logic [DW-1:0]   per_wdata,
    input logic            cpu_ad_oe,
    input logic            cpu_rd,
    input logic            busy,
    input logic            overrun,
    input logic            ack_s
);
    // R3
    strobe_mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(per_rd && per_wr));

    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (per_wr && $past(per_wr)) |-> ($stable(per_wdata) && $stable(per_addr)));

    // R5
    release_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(per_rd) || $fell(per_wr)) |-> $past(ack_s));

    // R8
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(busy));

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(per_rd) || $rose(per_wr)) |-> $past(!busy));

    // R12
    oe_needs_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ad_oe |-> cpu_rd);
endmodule

bind cpu_periph_bridge bridge_chk #(.DW(DW), .PA_W(PA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .per_rd    (per_rd),
    .per_wr    (per_wr),
    .per_addr  (per_addr),
    .per_wdata (per_wdata),
    .cpu_ad_oe (cpu_ad_oe),
    .cpu_rd    (cpu_rd),
    .busy      (busy),
    .overrun   (overrun),
    .ack_s     (ack_s)
);

// File: tb/sim_cpu_periph_bridge.sv
`timescale 1ns/1ps
module sim_cpu_periph_bridge;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cpu_ad_in = 8'h00;
    logic [7:0] cpu_ad_out;
    logic       cpu_ad_oe;
    logic       cpu_ale = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic       per_rd, per_wr;
    logic [5:0] per_addr;
    logic [7:0] per_wdata;
    logic [7:0] per_rdata = 8'h00;
    logic       per_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cpu_periph_bridge u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_ad_in(cpu_ad_in), .cpu_ad_out(cpu_ad_out), .cpu_ad_oe(cpu_ad_oe),
        .cpu_ale(cpu_ale), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .per_rd(per_rd), .per_wr(per_wr), .per_addr(per_addr),
        .per_wdata(per_wdata), .per_rdata(per_rdata), .per_ack(per_ack)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cpu_addr(input logic [7:0] a);
        @(negedge clk); cpu_ad_in = a; cpu_ale = 1'b1;
        @(negedge clk); cpu_ale = 1'b0;
        @(negedge clk);
    endtask

    task automatic cpu_write(input logic [7:0] a, input logic [7:0] d);
        cpu_addr(a);
        cpu_ad_in = d; cpu_wr = 1'b1;
        @(negedge clk); cpu_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic cpu_read(input logic [7:0] a, output logic [7:0] v, output logic oe);
        cpu_addr(a);
        cpu_rd = 1'b1;
        @(negedge clk); v = cpu_ad_out; oe = cpu_ad_oe; cpu_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic status_is(input logic [7:0] exp, input string req);
        logic [7:0] v; logic oe;
        cpu_read(8'hFE, v, oe);
        chk(v == exp && oe, req, v, exp);
    endtask

    task automatic ack_pulse(input logic [7:0] rd);
        @(negedge clk); per_rdata = rd; per_ack = 1'b1;
        repeat (4) @(negedge clk);
        per_ack = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, prev, rdv;
        logic oe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!per_rd && !per_wr, "R1", {per_rd, per_wr}, 0);
        status_is(8'h00, "R1");

        // R3 / R7 write sweep over the whole window
        for (int a = 0; a < 64; a++) begin
            logic [7:0] d;
            d = 8'((a * 29 + 7) & 255);
            cpu_write(8'(a), d);
            chk(per_wr && !per_rd, "R3", {per_rd, per_wr}, 1);
            chk(per_addr == 6'(a), "R3", per_addr, a);
            chk(per_wdata == d, "R3", per_wdata, d);
            status_is(8'h01, "R7");
            chk(per_wr && per_wdata == d, "R3", per_wdata, d);
            ack_pulse(8'h00);
            chk(!per_wr, "R3", per_wr, 0);
            status_is(8'h00, "R7");
        end

        // R4 / R5 / R6 read sweep, two-step reads
        prev = 8'h00;
        for (int a = 0; a < 64; a++) begin
            rdv = 8'((a * 53 + 11) & 255);
            cpu_read(8'(a), v, oe);
            chk(oe && v == prev, "R4", v, prev);
            chk(per_rd && per_addr == 6'(a), "R4", per_addr, a);
            @(negedge clk); per_rdata = rdv; per_ack = 1'b1;
            @(negedge clk); chk(per_rd, "R5", per_rd, 1);
            @(negedge clk); chk(per_rd, "R5", per_rd, 1);
            @(negedge clk); chk(!per_rd, "R5", per_rd, 0);
            per_ack = 1'b0; per_rdata = 8'h00;
            repeat (3) @(negedge clk);
            cpu_read(8'hFF, v, oe);
            chk(oe && v == rdv, "R6", v, rdv);
            prev = rdv;
        end

        // R8 overrun while busy
        cpu_write(8'h10, 8'hA5);
        cpu_write(8'h20, 8'h3C);
        chk(per_wr && per_addr == 6'h10, "R8", per_addr, 6'h10);
        chk(per_wdata == 8'hA5, "R8", per_wdata, 8'hA5);
        cpu_read(8'h21, v, oe);
        chk(per_wr && !per_rd && per_addr == 6'h10, "R8", {per_rd, per_wr}, 1);
        status_is(8'h03, "R8");
        ack_pulse(8'h00);
        status_is(8'h02, "R8");
        // R9 write-one-to-clear
        cpu_write(8'hFE, 8'h00);
        status_is(8'h02, "R9");
        cpu_write(8'hFE, 8'h02);
        status_is(8'h00, "R9");

        // R10 acknowledge held high
        cpu_write(8'h01, 8'h11);
        @(negedge clk); per_ack = 1'b1;
        repeat (4) @(negedge clk);
        chk(!per_wr, "R10", per_wr, 0);
        cpu_write(8'h02, 8'h44);
        repeat (8) @(negedge clk);
        chk(per_wr && per_addr == 6'h02, "R10", per_wr, 1);
        per_ack = 1'b0;
        repeat (3) @(negedge clk);
        chk(per_wr, "R10", per_wr, 1);
        per_ack = 1'b1;
        repeat (3) @(negedge clk);
        chk(!per_wr, "R10", per_wr, 0);
        per_ack = 1'b0;
        repeat (3) @(negedge clk);

        // R2 only the value at ALE fall is latched
        @(negedge clk); cpu_ad_in = 8'h30; cpu_ale = 1'b1;
        @(negedge clk); cpu_ad_in = 8'h07;
        @(negedge clk); cpu_ale = 1'b0;
        @(negedge clk); cpu_ad_in = 8'h99; cpu_wr = 1'b1;
        @(negedge clk); cpu_wr = 1'b0;
        @(negedge clk);
        chk(per_wr && per_addr == 6'h07 && per_wdata == 8'h99, "R2", per_addr, 7);
        ack_pulse(8'h00);

        // R11 / R12 unmapped sweep
        for (int a = 64; a < 254; a++) begin
            cpu_read(8'(a), v, oe);
            chk(!oe, "R12", oe, 0);
            chk(!per_rd && !per_wr, "R11", {per_rd, per_wr}, 0);
            cpu_write(8'(a), 8'h5A);
            chk(!per_rd && !per_wr, "R11", {per_rd, per_wr}, 0);
        end
        status_is(8'h00, "R11");
        cpu_read(8'hFF, v, oe);
        chk(oe && v == prev, "R11", v, prev);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule